// File: doc/BRIEF.md
# Coprocessor Start Gate

This block decides whether a graphics coprocessor may start executing after the host requests a run. On each go request it looks at the program bank, the program counter, the two memory-access enables from the screen mode register, and the instruction-cache state. It then returns a registered verdict one cycle later.

The checks run in a fixed priority order:
1. A program counter inside the active cache window always wins.
2. Otherwise, the forbidden bank ranges are rejected.
3. Otherwise, the work-RAM banks require the RAM-access enable.
4. Every remaining bank is treated as ROM and requires the ROM-access enable.

On a permitted start the block sets the go flag, captures the start bank and program counter, and clears the pending interrupt flag. On a rejected start it clears the go flag and leaves the captured bank, program counter and interrupt flag as they were.

The block has no data stream. All pins are plain control and status signals. The host raises `go_req` for one cycle per request, and the block places no back-pressure on it: every request is evaluated.

Top module: `ssv_start_gate`

## Requirements
- R1: When `cache_on` is 1 and `cache_base <= prg_pc < cache_base + 512`, the start is permitted for every bank and every enable setting. The upper bound is computed in 17 bits, so the window never wraps past 0xFFFF.
- R2: Without a cache-window hit, banks 0x60 to 0x6F are always rejected.
- R3: Without a cache-window hit, banks 0x74 to 0xFF are always rejected.
- R4: Without a cache-window hit, banks 0x70 to 0x73 are permitted only when `mode_ram_en` is 1. `mode_rom_en` has no effect on them.
- R5: Without a cache-window hit, banks 0x00 to 0x5F are permitted only when `mode_rom_en` is 1. `mode_ram_en` has no effect on them.
- R6: Exactly one of `start_ok` and `start_reject` is high for one cycle, in the cycle after a cycle with `go_req` high. Neither is high at any other time.
- R7: A rejected start clears `go_flag` and leaves `exec_bank` and `exec_pc` unchanged. A permitted start sets `go_flag` and loads `exec_bank` and `exec_pc` from `prg_bank` and `prg_pc`.
- R8: A permitted start clears `irq_pending`, and this clear has priority over `irq_set` in the same cycle. Otherwise `irq_set` sets `irq_pending`, and a rejected start leaves it unchanged.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_req | input | 1 | One-cycle start request from the host |
| prg_bank | input | 8 | Program bank of the requested start |
| prg_pc | input | 16 | Program counter of the requested start |
| mode_ram_en | input | 1 | Screen-mode RAM-access enable |
| mode_rom_en | input | 1 | Screen-mode ROM-access enable |
| cache_on | input | 1 | Instruction cache holds a valid window |
| cache_base | input | 16 | First address of the cache window |
| irq_set | input | 1 | Raises the pending interrupt flag |
| start_ok | output | 1 | One-cycle pulse: start permitted |
| start_reject | output | 1 | One-cycle pulse: start refused |
| go_flag | output | 1 | Coprocessor running flag |
| irq_pending | output | 1 | Pending interrupt flag |
| exec_bank | output | 8 | Bank captured at the last permitted start |
| exec_pc | output | 16 | Program counter captured at the last permitted start |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it:
- The verdict pulses, `go_flag`, `exec_bank`, `exec_pc` and `irq_pending` all follow the edge that samples `go_req` or `irq_set`.
- The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a cycle after the register update.
- One cycle later it checks that the pulse has dropped again.

Ignored enables and rejected starts are judged from the ports: the bench compares the captured bank and program counter with the values it recorded from the last permitted start.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

  typedef enum logic [1:0] {
    KIND_ROM    = 2'd0,
    KIND_RAM    = 2'd1,
    KIND_FORBID = 2'd2
  } bank_kind_e;

endpackage

// File: rtl/ssv_bank_classify.sv
module ssv_bank_classify
  import ssv_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter logic [BANK_W-1:0] HOLE_LO = 8'h60,
  parameter logic [BANK_W-1:0] HOLE_HI = 8'h6F,
  parameter logic [BANK_W-1:0] RAM_LO  = 8'h70,
  parameter logic [BANK_W-1:0] RAM_HI  = 8'h73
) (
  input  logic [BANK_W-1:0] bank,
  output bank_kind_e        kind
);

  logic in_hole;
  logic in_ram;
  logic above_ram;

  assign in_hole   = (bank >= HOLE_LO) && (bank <= HOLE_HI);
  assign in_ram    = (bank >= RAM_LO) && (bank <= RAM_HI);
  assign above_ram = (bank > RAM_HI);

  always_comb begin
    if (in_hole || above_ram) kind = KIND_FORBID;
    else if (in_ram)          kind = KIND_RAM;
    else                      kind = KIND_ROM;
  end

endmodule

// File: rtl/ssv_cache_window.sv
module ssv_cache_window #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 512
) (
  input  logic              cache_on,
  input  logic [ADDR_W-1:0] cache_base,
  input  logic [ADDR_W-1:0] pc,
  output logic              hit
);

  localparam int unsigned EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] WIN_EXT = EXT_W'(WIN_BYTES);

  logic [EXT_W-1:0] lo_ext;
  logic [EXT_W-1:0] hi_ext;
  logic [EXT_W-1:0] pc_ext;

  assign lo_ext = {1'b0, cache_base};
  assign hi_ext = lo_ext + WIN_EXT;
  assign pc_ext = {1'b0, pc};
  assign hit    = cache_on && (pc_ext >= lo_ext) && (pc_ext < hi_ext);

endmodule

// File: rtl/ssv_gate_decide.sv
module ssv_gate_decide
  import ssv_pkg::*;
(
  input  logic       cache_hit,
  input  bank_kind_e kind,
  input  logic       ram_en,
  input  logic       rom_en,
  output logic       permit
);

  always_comb begin
    if (cache_hit) begin
      permit = 1'b1;
    end else begin
      unique case (kind)
        KIND_FORBID: permit = 1'b0;
        KIND_RAM:    permit = ram_en;
        KIND_ROM:    permit = rom_en;
        default:     permit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ssv_start_gate.sv
module ssv_start_gate
  import ssv_pkg::*;
#(
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic [BANK_W-1:0] prg_bank,
  input  logic [ADDR_W-1:0] prg_pc,
  input  logic              mode_ram_en,
  input  logic              mode_rom_en,
  input  logic              cache_on,
  input  logic [ADDR_W-1:0] cache_base,
  input  logic              irq_set,
  output logic              start_ok,
  output logic              start_reject,
  output logic              go_flag,
  output logic              irq_pending,
  output logic [BANK_W-1:0] exec_bank,
  output logic [ADDR_W-1:0] exec_pc
);

  bank_kind_e kind;
  logic       win_hit;
  logic       permit;
  logic       take;

  ssv_bank_classify #(.BANK_W(BANK_W)) u_class (
    .bank (prg_bank),
    .kind (kind)
  );

  ssv_cache_window #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_win (
    .cache_on   (cache_on),
    .cache_base (cache_base),
    .pc         (prg_pc),
    .hit        (win_hit)
  );

  ssv_gate_decide u_dec (
    .cache_hit (win_hit),
    .kind      (kind),
    .ram_en    (mode_ram_en),
    .rom_en    (mode_rom_en),
    .permit    (permit)
  );

  assign take = go_req && permit;

  // Verdict pulses, one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ok     <= 1'b0;
      start_reject <= 1'b0;
    end else begin
      start_ok     <= take;
      start_reject <= go_req && !permit;
    end
  end

  // Running flag follows each verdict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      go_flag <= 1'b0;
    else if (go_req) go_flag <= permit;
  end

  // Start point captured only on a permitted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_bank <= '0;
      exec_pc   <= '0;
    end else if (take) begin
      exec_bank <= prg_bank;
      exec_pc   <= prg_pc;
    end
  end

  // Interrupt flag: clear on start wins over set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_pending <= 1'b0;
    else if (take)    irq_pending <= 1'b0;
    else if (irq_set) irq_pending <= 1'b1;
  end

endmodule

// File: rtl/ssv_start_gate_chk.sv
module ssv_start_gate_chk #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_req,
  input logic [BANK_W-1:0] prg_bank,
  input logic              cache_on,
  input logic              start_ok,
  input logic              start_reject,
  input logic              go_flag,
  input logic              irq_pending,
  input logic [BANK_W-1:0] exec_bank,
  input logic [ADDR_W-1:0] exec_pc
);

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && start_reject)); // R6

  AST_VERDICT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok || start_reject) |-> $past(go_req)); // R6

  AST_REQ_GIVES_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> (start_ok || start_reject)); // R6

  AST_HOLE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !cache_on && prg_bank >= BANK_W'(8'h60) && prg_bank <= BANK_W'(8'h6F))
      |=> start_reject); // R2

  AST_HIGH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !cache_on && prg_bank >= BANK_W'(8'h74)) |=> start_reject); // R3

  AST_REJECT_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |-> !go_flag); // R7

  AST_OK_SETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> go_flag); // R7

  AST_REJECT_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |-> ($stable(exec_bank) && $stable(exec_pc))); // R7

  AST_OK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> !irq_pending); // R8

endmodule

bind ssv_start_gate ssv_start_gate_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .go_req       (go_req),
  .prg_bank     (prg_bank),
  .cache_on     (cache_on),
  .start_ok     (start_ok),
  .start_reject (start_reject),
  .go_flag      (go_flag),
  .irq_pending  (irq_pending),
  .exec_bank    (exec_bank),
  .exec_pc      (exec_pc)
);

// File: tb/sim_ssv_start_gate.sv
`timescale 1ns/1ps
module sim_ssv_start_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_req = 1'b0;
  logic [7:0]  prg_bank = '0;
  logic [15:0] prg_pc = '0;
  logic        mode_ram_en = 1'b0;
  logic        mode_rom_en = 1'b0;
  logic        cache_on = 1'b0;
  logic [15:0] cache_base = '0;
  logic        irq_set = 1'b0;
  logic        start_ok;
  logic        start_reject;
  logic        go_flag;
  logic        irq_pending;
  logic [7:0]  exec_bank;
  logic [15:0] exec_pc;

  int checks = 0;
  int failures = 0;

  // Bench-side expectation state
  logic        m_go = 1'b0;
  logic        m_irq = 1'b0;
  logic [7:0]  m_bank = '0;
  logic [15:0] m_pc = '0;

  always #5 clk = ~clk;

  ssv_start_gate u0 (
    .clk (clk), .rst_n (rst_n), .go_req (go_req), .prg_bank (prg_bank),
    .prg_pc (prg_pc), .mode_ram_en (mode_ram_en), .mode_rom_en (mode_rom_en),
    .cache_on (cache_on), .cache_base (cache_base), .irq_set (irq_set),
    .start_ok (start_ok), .start_reject (start_reject), .go_flag (go_flag),
    .irq_pending (irq_pending), .exec_bank (exec_bank), .exec_pc (exec_pc)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_permit(input logic [7:0] b, input logic [15:0] pc,
                                        input logic ram, input logic rom,
                                        input logic con, input logic [15:0] base);
    logic [16:0] hi;
    hi = {1'b0, base} + 17'd512;
    if (con && ({1'b0, pc} >= {1'b0, base}) && ({1'b0, pc} < hi)) return 1'b1; // R1
    if (b >= 8'h60 && b <= 8'h6F) return 1'b0;  // R2
    if (b >= 8'h74) return 1'b0;                // R3
    if (b >= 8'h70) return ram;                 // R4
    return rom;                                 // R5
  endfunction

  // One request: drive at a falling edge, check one edge later, then check the drop
  task automatic do_go(input logic [7:0] b, input logic [15:0] pc, input logic ram,
                       input logic rom, input logic con, input logic [15:0] base,
                       input logic irq, input string tag);
    logic p;
    p = model_permit(b, pc, ram, rom, con, base);
    prg_bank = b; prg_pc = pc; mode_ram_en = ram; mode_rom_en = rom;
    cache_on = con; cache_base = base; irq_set = irq; go_req = 1'b1;
    @(negedge clk);
    go_req = 1'b0; irq_set = 1'b0;
    m_go = p;
    if (p) begin m_bank = b; m_pc = pc; m_irq = 1'b0; end
    else if (irq) m_irq = 1'b1;
    chk(start_ok == p && start_reject == !p, {tag, " verdict R6"},
        {start_ok, start_reject}, {p, !p});
    chk(go_flag == m_go, {tag, " go_flag R7"}, go_flag, m_go);
    chk(exec_bank == m_bank && exec_pc == m_pc, {tag, " start point R7"},
        {exec_bank, exec_pc}, {m_bank, m_pc});
    chk(irq_pending == m_irq, {tag, " irq R8"}, irq_pending, m_irq);
    @(negedge clk);
    chk(!start_ok && !start_reject, {tag, " pulse drop R6"}, {start_ok, start_reject}, 0);
  endtask

  task automatic t_reset();
    chk(!start_ok && !start_reject && !go_flag && !irq_pending && exec_bank == 0 && exec_pc == 0,
        "reset R9", {start_ok, start_reject, go_flag, irq_pending, exec_bank, exec_pc}, 0);
  endtask

  task automatic t_idle();
    repeat (4) @(negedge clk);
    chk(!start_ok && !start_reject, "idle no pulse R6", {start_ok, start_reject}, 0);
  endtask

  // Every bank, every enable pair, three cache situations (R1 to R5)
  task automatic t_sweep();
    for (int b = 0; b < 256; b++) begin
      for (int e = 0; e < 4; e++) begin
        for (int c = 0; c < 3; c++) begin
          logic [15:0] pc;
          logic [15:0] base;
          logic con;
          pc   = 16'h8000 + 16'(b * 7 + e);
          con  = (c != 0);
          base = (c == 1) ? pc - 16'd4 : pc + 16'd1;
          do_go(8'(b), pc, e[0], e[1], con, base, 1'b0, "sweep R1 R2 R3 R4 R5");
        end
      end
    end
  endtask

  // Window edges (R1)
  task automatic t_window();
    do_go(8'h65, 16'h11FF, 1'b0, 1'b0, 1'b1, 16'h1000, 1'b0, "window last byte R1");
    do_go(8'h65, 16'h1200, 1'b0, 1'b0, 1'b1, 16'h1000, 1'b0, "window past end R1");
    do_go(8'h80, 16'h1000, 1'b0, 1'b0, 1'b1, 16'h1000, 1'b0, "window first byte R1");
    do_go(8'h80, 16'h0FFF, 1'b0, 1'b0, 1'b1, 16'h1000, 1'b0, "window before base R1");
    do_go(8'hF0, 16'h0005, 1'b0, 1'b0, 1'b1, 16'hFF00, 1'b0, "window no wrap R1");
    do_go(8'hF0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'hFF00, 1'b0, "window top of space R1");
  endtask

  // Rejected start keeps start point (R7), enables ignored per kind (R4 R5)
  task automatic t_keep();
    do_go(8'h12, 16'hABCD, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, "permit rom R5");
    do_go(8'h71, 16'h4444, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, "ram bank rom_en ignored R4");
    do_go(8'h20, 16'h5555, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, "rom bank ram_en ignored R5");
    do_go(8'h73, 16'h6666, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, "permit ram R4");
    do_go(8'h60, 16'h7777, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, "hole keeps start R7");
  endtask

  // Interrupt flag behaviour (R8)
  task automatic t_irq();
    irq_set = 1'b1;
    @(negedge clk);
    irq_set = 1'b0;
    m_irq = 1'b1;
    chk(irq_pending == 1'b1, "irq set R8", irq_pending, 1);
    do_go(8'h6A, 16'h0100, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, "reject keeps irq R8");
    do_go(8'h01, 16'h0200, 1'b0, 1'b1, 1'b0, 16'h0, 1'b1, "permit beats irq_set R8");
    do_go(8'h90, 16'h0300, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, "reject with irq_set R8");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_keep();
    t_window();
    t_irq();
    t_sweep();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule